// File: doc/BRIEF.md
# Sequential Non-Restoring Integer Divider

This block divides two integers of `DATA_W` bits (32 by default) and returns either the quotient or the remainder. Signed and unsigned forms are both supported, with RISC-V M-extension results. A 2-bit operation code selects the operation. The requester raises `cmd_valid_i` and holds the code and both operands steady while it is high. It takes `result_o` in the cycle where `result_ready_o` is high, and it may drop `cmd_valid_i` in that same cycle. The divider works on signed operands directly. Each clock produces one quotient bit. At each step the divisor is added to or subtracted from the shifted partial remainder, and the choice depends on the previous quotient bit. An optional final cycle fixes the sign of the quotient or of the remainder.

The controller has three states.
- `ST_IDLE` (00) waits for a command.
- `ST_STEP` (01) runs the quotient-bit steps.
- `ST_FIX` (10) is the single correction cycle.

The transitions are as follows.
- ST_IDLE to ST_STEP: a valid command whose two operands are both nonzero.
- ST_IDLE to ST_IDLE: no command, or a command with a zero operand, which is answered at once.
- ST_STEP to ST_STEP: more steps remain.
- ST_STEP to ST_FIX: the last step finishes and the result needs a sign fix.
- ST_STEP to ST_IDLE: the last step finishes and no fix is needed.
- ST_FIX to ST_IDLE: always, after one cycle.
- Any state to ST_IDLE: `cmd_valid_i` is low.

A one-hot step counter sets the number of steps. It is loaded at bit `DATA_W-2` when a command starts and shifts right once per step. The last step is the one where bit 0 is set. The first quotient bit is produced in the idle cycle that accepts the command, so a division covers `DATA_W` quotient bits in all.

Top module: `nr_divider`

## Requirements
- R1: After reset the controller is idle and `result_ready_o` is high while `cmd_valid_i` is low.
- R2: `op_code_i` bit 1 selects remainder (1) or quotient (0), and bit 0 selects unsigned (1) or signed (0): 00 signed quotient, 01 unsigned quotient, 10 signed remainder, 11 unsigned remainder. For nonzero operands, the quotient is truncated toward zero and a nonzero remainder takes the sign of the dividend.
- R3: If either operand is zero, `result_ready_o` is high in the same cycle as the command. The result is all ones for a quotient with a zero divisor, and the dividend in every other case.
- R4: With both operands nonzero, `result_ready_o` stays low until `DATA_W-1` rising edges after the command is first presented. Without a correction it rises exactly then. An unsigned quotient never needs a correction.
- R5: A signed quotient whose operands differ in sign, and a nonzero remainder whose sign disagrees with the dividend, each take one correction cycle, so ready rises `DATA_W` edges after the command. A signed quotient whose operands share a sign completes without a correction cycle.
- R6: The most negative dividend divided by -1 gives a signed quotient equal to the most negative value and a signed remainder of 0.
- R7: A negative dividend that is an exact multiple of the divisor, where a partial remainder equals the divisor, gives the exact quotient and a remainder of 0.
- R8: If `cmd_valid_i` is dropped before ready, the controller is idle on the next edge, with ready high while valid stays low. The next command is then computed correctly, with normal latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present; code and operands held while high |
| op_code_i | input | 2 | Bit 1: remainder; bit 0: unsigned |
| dividend_i | input | DATA_W | Dividend |
| divisor_i | input | DATA_W | Divisor |
| result_o | output | DATA_W | Quotient or remainder, valid when ready is high |
| result_ready_o | output | 1 | Result available this cycle |

## Verification
The bench builds one copy with `DATA_W = 5` and sweeps every code against every pair of operands, 4096 commands in all. At that width every sign combination, the overflow pair (-16 by -1), every zero operand and every exact negative multiple are reachable exhaustively, and the bench checks the correction latency for each pair. A second copy at the default 32 bits takes directed corner cases and random operands. This confirms that the one-hot counter and the sign handling scale to full width.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_STEP = 2'b01,
        ST_FIX  = 2'b10
    } div_state_e;

    // Operation code field positions
    localparam int unsigned OPC_REM_BIT = 1;
    localparam int unsigned OPC_UNS_BIT = 0;

endpackage

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
    import nrdiv_pkg::*;
#(
    parameter int unsigned CNT_W = 31
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       valid_i,
    input  logic       go_i,
    input  logic       fix_req_i,
    output div_state_e state_o,
    output logic       last_o,
    output logic       ready_o,
    output logic       adv_o
);

    localparam logic [CNT_W-1:0] CNT_INIT = {1'b1, {(CNT_W-1){1'b0}}};

    div_state_e       state_q;
    div_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             start;

    assign start   = valid_i & go_i;
    assign last_o  = cnt_q[0];
    assign adv_o   = valid_i & ~ready_o;
    assign state_o = state_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = ST_IDLE;
        if (valid_i) begin
            unique case (state_q)
                ST_IDLE: state_d = start ? ST_STEP : ST_IDLE;
                ST_STEP: state_d = !last_o  ? ST_STEP
                                 : fix_req_i ? ST_FIX
                                             : ST_IDLE;
                ST_FIX:  state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ready_o = 1'b1;
        unique case (state_q)
            ST_IDLE: ready_o = ~start;
            ST_STEP: ready_o = last_o & ~fix_req_i;
            ST_FIX:  ready_o = 1'b1;
            default: ready_o = 1'b1;
        endcase
    end

    // One-hot step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_INIT;
        end else if (adv_o) begin
            cnt_q <= (state_q == ST_IDLE) ? CNT_INIT : (cnt_q >> 1);
        end
    end

    // R5
    fix_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FIX |=> state_q == ST_IDLE);

    // R4
    cnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cnt_q));

    // R4
    early_ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && !last_o) |-> !ready_o);

    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !valid_i) |=> state_q == ST_IDLE);

endmodule

// File: rtl/nrdiv_step.sv
module nrdiv_step
    import nrdiv_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  div_state_e        state_i,
    input  logic [1:0]        op_code_i,
    input  logic [DATA_W-1:0] dividend_i,
    input  logic [DATA_W-1:0] divisor_i,
    input  logic [DATA_W-1:0] rem_q_i,
    input  logic              carry_q_i,
    input  logic [DATA_W-1:0] quo_q_i,
    input  logic [DATA_W-1:0] dlo_q_i,
    output logic [DATA_W-1:0] rem_d_o,
    output logic              carry_d_o,
    output logic [DATA_W-1:0] quo_d_o,
    output logic [DATA_W-1:0] dlo_d_o,
    output logic              fix_req_o
);

    localparam int unsigned MSB = DATA_W - 1;

    logic          is_uns;
    logic          is_rem;
    logic          dvd_neg;
    logic          dsr_neg;
    logic          flip;
    logic          keep_sign;
    logic          do_sub;
    logic          qbit;
    logic [DATA_W:0] acc;
    logic [DATA_W:0] dsr_ext;
    logic [DATA_W:0] sum;

    assign is_uns  = op_code_i[OPC_UNS_BIT];
    assign is_rem  = op_code_i[OPC_REM_BIT];
    assign dvd_neg = ~is_uns & dividend_i[MSB];
    assign dsr_neg = ~is_uns & divisor_i[MSB];
    assign flip    = ~is_uns & (dividend_i[MSB] ^ divisor_i[MSB]);
    assign dsr_ext = {dsr_neg, divisor_i};

    // Partial remainder source and add/sub selection
    always_comb begin
        acc       = '0;
        keep_sign = 1'b0;
        dlo_d_o   = dlo_q_i;
        unique case (state_i)
            ST_IDLE: begin
                acc       = {{DATA_W{dvd_neg}}, dividend_i[MSB]};
                keep_sign = 1'b0;
                dlo_d_o   = dividend_i << 1;
            end
            ST_STEP: begin
                acc       = {rem_q_i, dlo_q_i[MSB]};
                keep_sign = ~quo_q_i[0];
                dlo_d_o   = dlo_q_i << 1;
            end
            ST_FIX: begin
                acc       = {1'b0, rem_q_i};
                keep_sign = dvd_neg ^ carry_q_i;
                dlo_d_o   = dlo_q_i;
            end
            default: begin
                acc       = '0;
                keep_sign = 1'b0;
                dlo_d_o   = dlo_q_i;
            end
        endcase
    end

    assign do_sub = ~flip ^ keep_sign;
    assign sum    = do_sub ? (acc - dsr_ext) : (acc + dsr_ext);

    assign rem_d_o   = sum[MSB:0];
    assign carry_d_o = sum[DATA_W];

    // Quotient bit, including the exact-multiple case for negative dividends
    assign qbit = ~(dvd_neg ^ sum[DATA_W])
                | (dvd_neg & (sum == '0) & (dlo_d_o == '0));

    always_comb begin
        quo_d_o = quo_q_i;
        unique case (state_i)
            ST_IDLE: quo_d_o = {{(DATA_W-1){1'b0}}, qbit};
            ST_STEP: quo_d_o = {quo_q_i[MSB-1:0], qbit};
            ST_FIX:  quo_d_o = quo_q_i;
            default: quo_d_o = quo_q_i;
        endcase
    end

    // Correction needed after the final step
    assign fix_req_o = (~is_rem & ~is_uns & (dividend_i[MSB] ^ divisor_i[MSB]))
                     | (is_rem & (|sum[MSB:0]) & (dvd_neg ^ sum[DATA_W]));

endmodule

// File: rtl/nrdiv_result.sv
module nrdiv_result
    import nrdiv_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  div_state_e        state_i,
    input  logic [1:0]        op_code_i,
    input  logic [DATA_W-1:0] dividend_i,
    input  logic [DATA_W-1:0] divisor_i,
    input  logic [DATA_W-1:0] rem_d_i,
    input  logic [DATA_W-1:0] quo_d_i,
    input  logic [DATA_W-1:0] quo_q_i,
    output logic [DATA_W-1:0] result_o
);

    logic is_rem;

    assign is_rem = op_code_i[OPC_REM_BIT];

    always_comb begin
        result_o = '0;
        unique case (state_i)
            ST_IDLE: result_o = ((|divisor_i) | is_rem) ? dividend_i : '1;
            ST_STEP: result_o = is_rem ? rem_d_i : quo_d_i;
            ST_FIX:  result_o = is_rem ? rem_d_i : (~quo_q_i + 1'b1);
            default: result_o = '0;
        endcase
    end

endmodule

// File: rtl/nr_divider.sv
module nr_divider
    import nrdiv_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [1:0]        op_code_i,
    input  logic [DATA_W-1:0] dividend_i,
    input  logic [DATA_W-1:0] divisor_i,
    output logic [DATA_W-1:0] result_o,
    output logic              result_ready_o
);

    localparam int unsigned CNT_W = DATA_W - 1;

    div_state_e        state;
    logic              last;
    logic              adv;
    logic              fix_req;
    logic              go;
    logic [DATA_W-1:0] rem_q, rem_d;
    logic              carry_q, carry_d;
    logic [DATA_W-1:0] quo_q, quo_d;
    logic [DATA_W-1:0] dlo_q, dlo_d;

    assign go = (|dividend_i) & (|divisor_i);

    nrdiv_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (cmd_valid_i),
        .go_i      (go),
        .fix_req_i (fix_req),
        .state_o   (state),
        .last_o    (last),
        .ready_o   (result_ready_o),
        .adv_o     (adv)
    );

    nrdiv_step #(.DATA_W(DATA_W)) u_step (
        .state_i    (state),
        .op_code_i  (op_code_i),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .rem_q_i    (rem_q),
        .carry_q_i  (carry_q),
        .quo_q_i    (quo_q),
        .dlo_q_i    (dlo_q),
        .rem_d_o    (rem_d),
        .carry_d_o  (carry_d),
        .quo_d_o    (quo_d),
        .dlo_d_o    (dlo_d),
        .fix_req_o  (fix_req)
    );

    nrdiv_result #(.DATA_W(DATA_W)) u_result (
        .state_i    (state),
        .op_code_i  (op_code_i),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .rem_d_i    (rem_d),
        .quo_d_i    (quo_d),
        .quo_q_i    (quo_q),
        .result_o   (result_o)
    );

    // Working registers: partial remainder with carry, quotient, dividend tail
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q   <= '0;
            carry_q <= 1'b0;
            quo_q   <= '0;
            dlo_q   <= '0;
        end else if (adv) begin
            rem_q   <= rem_d;
            carry_q <= carry_d;
            quo_q   <= quo_d;
            dlo_q   <= dlo_d;
        end
    end

    // R3
    zero_divisor_quo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_valid_i && divisor_i == '0 && !op_code_i[OPC_REM_BIT])
            |-> (result_ready_o && result_o == '1));

    // R4
    start_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_valid_i && dividend_i != '0 && divisor_i != '0)
            |=> state == ST_STEP);

    // R1
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !cmd_valid_i) |-> result_ready_o);

endmodule

// File: tb/nr_divider_tb.sv
module nr_divider_tb;

    localparam int NW = 5;
    localparam int WW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          v_n = 1'b0, v_w = 1'b0;
    logic [1:0]    c_n = '0, c_w = '0;
    logic [NW-1:0] a_n = '0, b_n = '0;
    logic [WW-1:0] a_w = '0, b_w = '0;
    logic [NW-1:0] r_n;
    logic [WW-1:0] r_w;
    logic          rdy_n, rdy_w;

    int checks = 0;
    int errors = 0;

    nr_divider #(.DATA_W(NW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(v_n), .op_code_i(c_n),
        .dividend_i(a_n), .divisor_i(b_n), .result_o(r_n), .result_ready_o(rdy_n)
    );

    nr_divider #(.DATA_W(WW)) u_dut_wide (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(v_w), .op_code_i(c_w),
        .dividend_i(a_w), .divisor_i(b_w), .result_o(r_w), .result_ready_o(rdy_w)
    );

    // Reference result per R2, R3, R6
    function automatic longint ref_val(int w, logic [1:0] code, longint a, longint b);
        longint mask, half, sa, sb, q, r;
        mask = (longint'(1) << w) - 1;
        half = longint'(1) << (w - 1);
        if (b == 0) return code[1] ? a : mask;
        if (code[0]) return code[1] ? (a % b) : (a / b);
        sa = (a ^ half) - half;
        sb = (b ^ half) - half;
        if (sa == -half && sb == -1) begin
            q = sa;
            r = 0;
        end else begin
            q = sa / sb;
            r = sa % sb;
        end
        return (code[1] ? r : q) & mask;
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic run(bit wide, logic [1:0] code, logic [31:0] a, logic [31:0] b, string tag);
        int w, lat;
        longint av, bv, exp, got;
        bit sa, sb;
        w  = wide ? WW : NW;
        av = wide ? longint'(a) : longint'(a[NW-1:0]);
        bv = wide ? longint'(b) : longint'(b[NW-1:0]);
        @(negedge clk);
        if (wide) begin
            c_w = code; a_w = a; b_w = b; v_w = 1'b1;
        end else begin
            c_n = code; a_n = a[NW-1:0]; b_n = b[NW-1:0]; v_n = 1'b1;
        end
        #1;
        lat = 0;
        while (!(wide ? rdy_w : rdy_n) && lat < 40) begin
            @(negedge clk);
            lat++;
            #1;
        end
        got = wide ? longint'(r_w) : longint'(r_n);
        v_w = 1'b0;
        v_n = 1'b0;
        exp = ref_val(w, code, av, bv);
        check(got == exp, tag, "result", got, exp);
        sa = wide ? a[WW-1] : a[NW-1];
        sb = wide ? b[WW-1] : b[NW-1];
        if (av == 0 || bv == 0)
            check(lat == 0, "R3", "latency", lat, 0);
        else if (code == 2'b01)
            check(lat == w - 1, "R4", "latency", lat, w - 1);
        else if (code == 2'b00)
            check(lat == ((sa != sb) ? w : w - 1), "R5", "latency", lat, (sa != sb) ? w : w - 1);
        else
            check(lat == w - 1 || lat == w, "R5", "latency", lat, w);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: idle after reset, ready with no command
        check(rdy_n == 1'b1, "R1", "ready narrow", rdy_n, 1);
        check(rdy_w == 1'b1, "R1", "ready wide", rdy_w, 1);

        // R2: exhaustive sweep of the narrow copy
        for (int code = 0; code < 4; code++)
            for (int a = 0; a < 32; a++)
                for (int b = 0; b < 32; b++)
                    run(1'b0, 2'(code), 32'(a), 32'(b), "R2");

        // R6: overflow pair, narrow and wide
        run(1'b0, 2'b00, 32'h10, 32'h1F, "R6");
        run(1'b0, 2'b10, 32'h10, 32'h1F, "R6");
        run(1'b1, 2'b00, 32'h8000_0000, 32'hFFFF_FFFF, "R6");
        run(1'b1, 2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R6");

        // R7: negative dividend that is an exact multiple
        run(1'b1, 2'b00, 32'hFFFF_FFFC, 32'd2, "R7");
        run(1'b1, 2'b10, 32'hFFFF_FFFC, 32'd2, "R7");
        run(1'b1, 2'b00, 32'hFFFF_FFF7, 32'hFFFF_FFFD, "R7");
        run(1'b1, 2'b10, 32'hFFFF_FFF7, 32'hFFFF_FFFD, "R7");
        run(1'b1, 2'b00, 32'h8000_0000, 32'd2, "R7");
        run(1'b1, 2'b10, 32'h8000_0000, 32'h4000_0000, "R7");

        // R3: zero operands at full width
        run(1'b1, 2'b00, 32'd1234, 32'd0, "R3");
        run(1'b1, 2'b01, 32'd1234, 32'd0, "R3");
        run(1'b1, 2'b10, 32'hFFFF_0000, 32'd0, "R3");
        run(1'b1, 2'b11, 32'd0, 32'd77, "R3");

        // R2: unit operands and mixed signs at full width
        run(1'b1, 2'b00, 32'hFFFF_FFFF, 32'd1, "R2");
        run(1'b1, 2'b01, 32'hFFFF_FFFF, 32'd1, "R2");
        run(1'b1, 2'b00, 32'd7, 32'hFFFF_FFFF, "R2");
        run(1'b1, 2'b10, 32'hFFFF_FFF9, 32'd2, "R2");
        run(1'b1, 2'b11, 32'hFFFF_FFF9, 32'd2, "R2");
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (i % 3 == 1) rb = rb >> (i % 29);
            if (i % 5 == 2) ra = ra >> (i % 31);
            run(1'b1, 2'(i % 4), ra, rb, "R2");
        end

        // R8: abort mid-division, then a fresh command
        @(negedge clk);
        c_n = 2'b00; a_n = 5'd13; b_n = 5'd3; v_n = 1'b1;
        repeat (2) @(negedge clk);
        v_n = 1'b0;
        @(negedge clk);
        #1;
        check(rdy_n == 1'b1, "R8", "ready after abort", rdy_n, 1);
        run(1'b0, 2'b00, 32'd13, 32'd3, "R8");
        run(1'b0, 2'b10, 32'h13, 32'd3, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule